// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block gives a machine-mode trap unit a second layer of interrupt state for non-maskable interrupts that software can return from. It holds four control registers: a scratch word, a saved program counter, a cause word and a status word. The status word carries an enable bit. Software can set this bit but cannot clear it. When the bit is set, a latched external request is taken ahead of every ordinary interrupt.

When the request is taken, the block saves the interrupted PC and privilege, clears the enable and enters machine mode. It then redirects fetch to a configurable handler vector. A return request undoes the entry: it restores the saved privilege, sets the enable again and redirects to the saved PC. While the enable is clear, a machine-level synchronous exception raised from machine mode is sent to a separate exception vector in place of the normal trap vector.

The surrounding trap unit drives ordinary privilege changes through a write port. It uses the redirect, reservation-cancel and MPRV-clear pulses that this block drives.

Top module: `rnmi_trap_ctl`

## Requirements
- R1: The registers answer at addresses 0x740 (scratch), 0x741 (saved PC), 0x742 (cause) and 0x744 (status). `csr_hit` is 1 only for these addresses while `priv` is machine (2'b11). In all other cases `csr_rdata` reads 0 and a write changes nothing.
- R2: In the status word, bits 12:11 hold the previous privilege, bit 7 holds the previous virtualization flag and bit 3 holds the enable. All other bits read 0. Without the hypervisor option, bit 7 stays 0 whatever is written.
- R3: A status write can only set the enable; the new enable is the old enable OR written bit 3. Only an RNMI entry clears it.
- R4: A written previous-privilege value is legalized. The value 2'b10 becomes user (2'b00). The value 2'b01 stays only if supervisor mode exists, otherwise it becomes user. Every value becomes machine if user mode is absent.
- R5: The saved PC has bit 0 cleared when compressed instructions are enabled (bits 1:0 cleared otherwise). A cause write changes bits XLEN-2:0 only; bit XLEN-1 keeps its value.
- R6: After reset, `priv` is 2'b11. The scratch, saved-PC and status registers read 0, and the cause register reads 0x80000000.
- R7: A rising edge of `rnmi_req` sets a pending flag. `rnmi_take` is pending AND enable, and it can rise at the earliest in the cycle after the edge. A request that stays high produces a single entry. While the enable is 0, the pending flag is held.
- R8: While `rnmi_take` is 1, the block raises `redirect_valid` with `redirect_pc` = `vec_int` and raises `resv_cancel`. On that clock edge the cause field becomes 0, the enable becomes 0, the previous privilege takes `priv`, the saved PC takes `instr_pc`, and `priv` becomes machine. Entry overrides a return or CSR write in the same cycle.
- R9: A return request at machine privilege raises `redirect_valid` with the masked saved PC and raises `resv_cancel`. It also raises `mprv_clr` if the saved privilege is not machine. On the next edge `priv` takes the saved privilege and the enable becomes 1.
- R10: A return request below machine privilege raises `mnret_illegal`. It gives no redirect, no cancel and no state change.
- R11: `exc_vec` equals `vec_exc` when the enable is 0 and `mpp_is_m` is 1. Otherwise it equals `mtvec`.
- R12: `priv_wr_en` loads `priv_wr_val`, legalized as in R4, into `priv` on the next edge. It has the lowest precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data, 0 on no hit |
| csr_hit | output | 1 | Address is one of the four registers and access is legal |
| rnmi_req | input | 1 | External resumable NMI request (level) |
| instr_pc | input | XLEN | PC of the interrupted instruction |
| rnmi_take | output | 1 | RNMI accepted this cycle |
| mnret_req | input | 1 | Return instruction retiring |
| mnret_illegal | output | 1 | Return attempted below machine mode |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| vec_int | input | XLEN | RNMI interrupt handler vector |
| vec_exc | input | XLEN | RNMI exception handler vector |
| mtvec | input | XLEN | Normal machine trap vector |
| mpp_is_m | input | 1 | mstatus previous privilege is machine |
| exc_vec | output | XLEN | Vector for a machine synchronous exception |
| priv_wr_en | input | 1 | Ordinary privilege update strobe |
| priv_wr_val | input | 2 | Ordinary privilege update value |
| priv | output | 2 | Current privilege |
| mprv_clr | output | 1 | Clear MPRV pulse on return |
| resv_cancel | output | 1 | Cancel load reservation pulse |

## Verification
CSR reads, `exc_vec`, the return redirect, `mnret_illegal` and `mprv_clr` are combinational. A write, an entry, a return or a privilege update shows up one edge later. A request edge first appears as `rnmi_take` one edge after the rise, and the entry state appears one edge after that. The bench drives inputs at falling edges and samples 1 ns after the next falling edge. Every result is therefore read exactly once per intervening rising edge, and the count of edges between stimulus and check matches these latencies.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;
   localparam logic [1:0] PRV_U   = 2'b00;
   localparam logic [1:0] PRV_S   = 2'b01;
   localparam logic [1:0] PRV_RSV = 2'b10;
   localparam logic [1:0] PRV_M   = 2'b11;

   localparam logic [11:0] ADR_SCRATCH = 12'h740;
   localparam logic [11:0] ADR_EPC     = 12'h741;
   localparam logic [11:0] ADR_CAUSE   = 12'h742;
   localparam logic [11:0] ADR_STATUS  = 12'h744;

   localparam int ST_PP_LO = 11;
   localparam int ST_PV    = 7;
   localparam int ST_EN    = 3;

   function automatic logic [1:0] legal_prv(input logic [1:0] v,
                                            input bit has_u,
                                            input bit has_s);
      logic [1:0] r;
      if (!has_u)              r = PRV_M;
      else if (v == PRV_RSV)   r = PRV_U;
      else if (v == PRV_S)     r = has_s ? PRV_S : PRV_U;
      else                     r = v;
      return r;
   endfunction
endpackage

// File: rtl/rnmi_pend.sv
module rnmi_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic accept,
   output logic pending
);
   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         pending <= 1'b0;
      end else begin
         req_q <= req;
         if (req && !req_q)
            pending <= 1'b1;
         else if (accept)
            pending <= 1'b0;
      end
   end
endmodule

// File: rtl/rnmi_csr_bank.sv
module rnmi_csr_bank
   import rnmi_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter bit HAS_U = 1'b1,
   parameter bit HAS_S = 1'b1,
   parameter bit HAS_H = 1'b0,
   parameter bit HAS_C = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_we,
   input  logic [11:0]     acc_addr,
   input  logic [XLEN-1:0] acc_wdata,
   output logic [XLEN-1:0] acc_rdata,
   output logic            acc_match,
   input  logic            ent_go,
   input  logic [XLEN-1:0] ent_pc,
   input  logic [1:0]      ent_prv,
   input  logic            ret_go,
   output logic            nmie,
   output logic [1:0]      mnpp,
   output logic [XLEN-1:0] epc_rd
);
   localparam int CW = XLEN - 1;
   localparam logic [XLEN-1:0] PC_MASK = {{(XLEN-2){1'b1}}, (HAS_C ? 2'b10 : 2'b00)};

   logic [XLEN-1:0] scratch_q, epc_q;
   logic [CW-1:0]   cause_q;
   logic            cause_irq_q;
   logic [1:0]      pp_q;
   logic            en_q;
   logic            pv;

   logic wr_scr, wr_epc, wr_cause, wr_st;
   assign wr_scr   = acc_we && (acc_addr == ADR_SCRATCH);
   assign wr_epc   = acc_we && (acc_addr == ADR_EPC);
   assign wr_cause = acc_we && (acc_addr == ADR_CAUSE);
   assign wr_st    = acc_we && (acc_addr == ADR_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scratch_q   <= '0;
         epc_q       <= '0;
         cause_q     <= '0;
         cause_irq_q <= 1'b1;
         pp_q        <= PRV_U;
         en_q        <= 1'b0;
      end else if (ent_go) begin
         cause_q <= '0;
         en_q    <= 1'b0;
         pp_q    <= ent_prv;
         epc_q   <= ent_pc & PC_MASK;
      end else if (ret_go) begin
         en_q <= 1'b1;
      end else begin
         if (wr_scr)   scratch_q <= acc_wdata;
         if (wr_epc)   epc_q     <= acc_wdata & PC_MASK;
         if (wr_cause) cause_q   <= acc_wdata[CW-1:0];
         if (wr_st) begin
            pp_q <= legal_prv(acc_wdata[ST_PP_LO+1:ST_PP_LO], HAS_U, HAS_S);
            en_q <= en_q | acc_wdata[ST_EN];
         end
      end
   end

   generate
      if (HAS_H) begin : g_pv
         logic pv_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        pv_q <= 1'b0;
            else if (wr_st && !ent_go && !ret_go) pv_q <= acc_wdata[ST_PV];
         end
         assign pv = pv_q;
      end else begin : g_no_pv
         assign pv = 1'b0;
      end
   endgenerate

   logic [XLEN-1:0] st_word;
   always_comb begin
      st_word = '0;
      st_word[ST_PP_LO+1:ST_PP_LO] = pp_q;
      st_word[ST_PV] = pv;
      st_word[ST_EN] = en_q;
   end

   always_comb begin
      acc_match = 1'b1;
      unique case (acc_addr)
         ADR_SCRATCH: acc_rdata = scratch_q;
         ADR_EPC:     acc_rdata = epc_q & PC_MASK;
         ADR_CAUSE:   acc_rdata = {cause_irq_q, cause_q};
         ADR_STATUS:  acc_rdata = st_word;
         default: begin
            acc_rdata = '0;
            acc_match = 1'b0;
         end
      endcase
   end

   assign nmie   = en_q;
   assign mnpp   = pp_q;
   assign epc_rd = epc_q & PC_MASK;
endmodule

// File: rtl/rnmi_trap_ctl.sv
module rnmi_trap_ctl
   import rnmi_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter bit HAS_U = 1'b1,
   parameter bit HAS_S = 1'b1,
   parameter bit HAS_H = 1'b0,
   parameter bit HAS_C = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            csr_we,
   input  logic [11:0]     csr_addr,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata,
   output logic            csr_hit,
   input  logic            rnmi_req,
   input  logic [XLEN-1:0] instr_pc,
   output logic            rnmi_take,
   input  logic            mnret_req,
   output logic            mnret_illegal,
   output logic            redirect_valid,
   output logic [XLEN-1:0] redirect_pc,
   input  logic [XLEN-1:0] vec_int,
   input  logic [XLEN-1:0] vec_exc,
   input  logic [XLEN-1:0] mtvec,
   input  logic            mpp_is_m,
   output logic [XLEN-1:0] exc_vec,
   input  logic            priv_wr_en,
   input  logic [1:0]      priv_wr_val,
   output logic [1:0]      priv,
   output logic            mprv_clr,
   output logic            resv_cancel
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("rnmi_trap_ctl: XLEN must be 32 or 64");
      end
      if (HAS_S && !HAS_U) begin : g_bad_modes
         $error("rnmi_trap_ctl: supervisor mode requires user mode");
      end
   endgenerate

   logic [1:0]      priv_q;
   logic            pending, nmie, in_m, ret_ok, raw_match, bank_we;
   logic [1:0]      mnpp;
   logic [XLEN-1:0] raw_rdata, epc_rd;

   assign in_m      = (priv_q == PRV_M);
   assign rnmi_take = pending && nmie;
   assign ret_ok    = mnret_req && in_m && !rnmi_take;

   rnmi_pend u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (rnmi_req),
      .accept  (rnmi_take),
      .pending (pending)
   );

   assign csr_hit   = raw_match && in_m;
   assign bank_we   = csr_we && csr_hit;
   assign csr_rdata = csr_hit ? raw_rdata : '0;

   rnmi_csr_bank #(
      .XLEN (XLEN), .HAS_U (HAS_U), .HAS_S (HAS_S), .HAS_H (HAS_H), .HAS_C (HAS_C)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_we    (bank_we),
      .acc_addr  (csr_addr),
      .acc_wdata (csr_wdata),
      .acc_rdata (raw_rdata),
      .acc_match (raw_match),
      .ent_go    (rnmi_take),
      .ent_pc    (instr_pc),
      .ent_prv   (priv_q),
      .ret_go    (ret_ok),
      .nmie      (nmie),
      .mnpp      (mnpp),
      .epc_rd    (epc_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          priv_q <= PRV_M;
      else if (rnmi_take)  priv_q <= PRV_M;
      else if (ret_ok)     priv_q <= mnpp;
      else if (priv_wr_en) priv_q <= legal_prv(priv_wr_val, HAS_U, HAS_S);
   end

   assign priv           = priv_q;
   assign mnret_illegal  = mnret_req && !in_m && !rnmi_take;
   assign redirect_valid = rnmi_take || ret_ok;
   assign redirect_pc    = rnmi_take ? vec_int : epc_rd;
   assign resv_cancel    = rnmi_take || ret_ok;
   assign mprv_clr       = ret_ok && (mnpp != PRV_M);
   assign exc_vec        = (!nmie && mpp_is_m) ? vec_exc : mtvec;
endmodule

// File: rtl/rnmi_trap_ctl_chk.sv
module rnmi_trap_ctl_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            csr_hit,
   input logic [XLEN-1:0] csr_rdata,
   input logic            rnmi_take,
   input logic            mnret_req,
   input logic            mnret_illegal,
   input logic            redirect_valid,
   input logic [XLEN-1:0] redirect_pc,
   input logic [XLEN-1:0] vec_int,
   input logic [1:0]      priv,
   input logic            resv_cancel,
   input logic            nmie
);
   // R1
   off_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_hit |-> csr_rdata == '0);
   // R1
   hit_needs_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_hit |-> priv == 2'b11);
   // R3
   nmie_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nmie && !rnmi_take) |=> nmie);
   // R8
   entry_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rnmi_take |-> (redirect_valid && redirect_pc == vec_int && resv_cancel));
   // R8
   entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rnmi_take |=> (priv == 2'b11 && !nmie && !rnmi_take));
   // R9
   ret_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mnret_req && priv == 2'b11 && !rnmi_take) |=> nmie);
   // R10
   ret_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mnret_illegal |-> (!redirect_valid && !resv_cancel));
endmodule

bind rnmi_trap_ctl rnmi_trap_ctl_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/rnmi_trap_ctl_tb.sv
`timescale 1ns/1ps
module rnmi_trap_ctl_tb;
   localparam int XLEN = 32;
   localparam logic [31:0] VI = 32'h0000_0100;
   localparam logic [31:0] VE = 32'h0000_0200;
   localparam logic [31:0] MT = 32'h0000_0300;

   logic clk = 1'b0, rst_n = 1'b0;
   logic csr_we = 0; logic [11:0] csr_addr = '0; logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata; logic csr_hit;
   logic rnmi_req = 0; logic [31:0] instr_pc = '0; logic rnmi_take;
   logic mnret_req = 0; logic mnret_illegal, redirect_valid; logic [31:0] redirect_pc;
   logic mpp_is_m = 0; logic [31:0] exc_vec;
   logic priv_wr_en = 0; logic [1:0] priv_wr_val = '0; logic [1:0] priv;
   logic mprv_clr, resv_cancel;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   rnmi_trap_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
      .rnmi_req(rnmi_req), .instr_pc(instr_pc), .rnmi_take(rnmi_take),
      .mnret_req(mnret_req), .mnret_illegal(mnret_illegal),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .vec_int(VI), .vec_exc(VE), .mtvec(MT), .mpp_is_m(mpp_is_m),
      .exc_vec(exc_vec), .priv_wr_en(priv_wr_en), .priv_wr_val(priv_wr_val),
      .priv(priv), .mprv_clr(mprv_clr), .resv_cancel(resv_cancel));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
      @(negedge clk); csr_we = 0; #1;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); csr_addr = a; #1; d = csr_rdata;
   endtask

   task automatic set_priv(input logic [1:0] p);
      @(negedge clk); priv_wr_en = 1; priv_wr_val = p;
      @(negedge clk); priv_wr_en = 0; #1;
   endtask

   logic [31:0] v;
   logic [31:0] scr_val;

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      nxt();
      // R6 reset state
      chk("R6 priv", {30'd0, priv}, 32'h3);
      rd(12'h740, v); chk("R6 scratch", v, 32'h0);
      rd(12'h741, v); chk("R6 epc", v, 32'h0);
      rd(12'h742, v); chk("R6 cause", v, 32'h8000_0000);
      rd(12'h744, v); chk("R6 status", v, 32'h0);
      rd(12'h743, v); chk("R1 unmapped rdata", v, 32'h0);
      chk("R1 unmapped hit", {31'd0, csr_hit}, 32'h0);

      // R11 sweep with enable clear
      for (int m = 0; m < 2; m++) begin
         mpp_is_m = m[0]; #1;
         chk("R11 nmie0", exc_vec, m ? VE : MT);
      end

      // R5 / R1 register writes
      scr_val = 32'hA5A5_0001;
      wr(12'h740, scr_val); rd(12'h740, v); chk("R1 scratch", v, scr_val);
      wr(12'h741, 32'h1234_5677); rd(12'h741, v); chk("R5 epc mask", v, 32'h1234_5676);
      wr(12'h742, 32'h0000_0005); rd(12'h742, v); chk("R5 cause field", v, 32'h8000_0005);

      // R7 pending held while enable is 0
      @(negedge clk); rnmi_req = 1;
      repeat (3) nxt();
      chk("R7 no take nmie0", {31'd0, rnmi_take}, 32'h0);
      instr_pc = 32'h0000_4001;
      wr(12'h744, 32'h0000_0008);
      chk("R7 take after enable", {31'd0, rnmi_take}, 32'h1);
      // R8 same-cycle return and scratch write lose to entry
      csr_we = 1; csr_addr = 12'h740; csr_wdata = 32'h55; mnret_req = 1; #1;
      chk("R8 redirect", redirect_pc, VI);
      chk("R8 cancel", {31'd0, resv_cancel}, 32'h1);
      @(negedge clk); csr_we = 0; mnret_req = 0; #1;
      chk("R8 priv", {30'd0, priv}, 32'h3);
      rd(12'h744, v); chk("R8 status", v, 32'h0000_1800);
      rd(12'h741, v); chk("R8 epc", v, 32'h0000_4000);
      rd(12'h742, v); chk("R8 cause", v, 32'h8000_0000);
      rd(12'h740, v); chk("R8 write blocked", v, scr_val);
      @(negedge clk); rnmi_req = 0;

      // R3 / R2 / R4 status writes
      wr(12'h744, 32'h0); rd(12'h744, v); chk("R4 pp user", v, 32'h0);
      wr(12'h744, 32'hFFFF_FFFF); rd(12'h744, v); chk("R2 layout", v, 32'h0000_1808);
      wr(12'h744, 32'h0); rd(12'h744, v); chk("R3 no clear", v, 32'h0000_0008);
      for (int p = 0; p < 4; p++) begin
         wr(12'h744, p << 11);
         rd(12'h744, v);
         chk("R4 legalize", v, ((p == 2) ? 32'h0 : (p << 11)) | 32'h8);
      end

      // R11 sweep with enable set
      for (int m = 0; m < 2; m++) begin
         mpp_is_m = m[0]; #1;
         chk("R11 nmie1", exc_vec, MT);
      end

      // R12 reserved privilege write
      set_priv(2'b10);
      chk("R12 legalized priv", {30'd0, priv}, 32'h0);
      set_priv(2'b11);

      // R8 / R9 / R10 entry and return from each privilege
      for (int k = 0; k < 3; k++) begin
         logic [1:0] p;
         logic [31:0] pc;
         p  = (k == 2) ? 2'b11 : k[1:0];
         pc = 32'h0000_2000 + k * 32'h10 + 32'h1;
         wr(12'h742, 32'h9);
         set_priv(p);
         if (p != 2'b11) begin
            wr(12'h740, 32'hDEAD_BEEF);
            rd(12'h740, v);
            chk("R1 no hit below M", {31'd0, csr_hit}, 32'h0);
            chk("R1 rdata below M", v, 32'h0);
         end
         instr_pc = pc;
         @(negedge clk); rnmi_req = 1;
         nxt();
         chk("R7 take", {31'd0, rnmi_take}, 32'h1);
         chk("R8 vec", redirect_pc, VI);
         nxt();
         chk("R8 priv M", {30'd0, priv}, 32'h3);
         rd(12'h744, v); chk("R8 pp saved", v, {19'd0, p, 11'd0});
         rd(12'h742, v); chk("R8 cause zero", v, 32'h8000_0000);
         rd(12'h741, v); chk("R8 pc saved", v, pc & 32'hFFFF_FFFE);
         rd(12'h740, v); chk("R1 scratch kept", v, scr_val);
         wr(12'h744, {19'd0, p, 11'd0} | 32'h8);
         repeat (2) nxt();
         chk("R7 held level one entry", {31'd0, rnmi_take}, 32'h0);
         rnmi_req = 0;
         @(negedge clk); mnret_req = 1; #1;
         chk("R9 redirect", {31'd0, redirect_valid}, 32'h1);
         chk("R9 target", redirect_pc, pc & 32'hFFFF_FFFE);
         chk("R9 mprv", {31'd0, mprv_clr}, {31'd0, p != 2'b11});
         chk("R9 cancel", {31'd0, resv_cancel}, 32'h1);
         @(negedge clk); mnret_req = 0; #1;
         chk("R9 priv restored", {30'd0, priv}, {30'd0, p});
         @(negedge clk); mnret_req = 1; #1;
         chk("R10 illegal", {31'd0, mnret_illegal}, {31'd0, p != 2'b11});
         if (p != 2'b11)
            chk("R10 no redirect", {31'd0, redirect_valid}, 32'h0);
         @(negedge clk); mnret_req = 0; #1;
         chk("R10 priv kept", {30'd0, priv}, {30'd0, p});
         set_priv(2'b11);
         rd(12'h744, v); chk("R9 enable set", v, {19'd0, p, 11'd0} | 32'h8);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule